// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block is the control-word front end of a PLL frequency synthesizer. It holds three configuration fields: a 9-bit feedback divider value, a 2-bit output divider select and a 2-bit test-mode field. It drives all three to the rest of the synthesizer. Software or board logic can write them in two ways. The first is a parallel path: the divider pins are captured when a load strobe rises. The second is a three-wire serial path: bits are shifted in on a serial clock, and then the whole frame is transferred at once by a separate load strobe.

The parallel strobe also selects the operating mode. While the strobe stays high after a parallel capture, the block is in serial mode. While the strobe is low, the block is in parallel mode. A status pin shows internal state in serial mode and is held low in parallel mode. A master reset input is synchronized and brought out to clear the downstream divider counters. It never touches the stored configuration. All strobe, clock and reset pins are asynchronous to the internal system clock. Each one passes through a two-flop synchronizer and an edge detector. Every register update happens on the system clock.

Top module: `synth_cfg_loader`

## Requirements
- R1: After power-on reset (rst_n low) the outputs are fb_div_o = 200, out_sel_o = 0, test_mode_o = 0, status_o = 0 and div_clear_o = 0, and the block is in parallel mode.
- R2: When pload_i rises, fb_div_o and out_sel_o take the values on par_div_i and par_sel_i, and test_mode_o becomes 0. The new values are visible no later than three system-clock cycles after the edge.
- R3: While pload_i does not rise, changes on par_div_i and par_sel_i do not alter any output field.
- R4: Each rising edge of ser_clk_i shifts the bit on ser_data_i into a 13-bit shift register, first bit first. After 13 shifts the first bit sent sits in the most significant position. Frame bit 12 down to 0 is: test mode bit 1, test mode bit 0, select bit 1, select bit 0, divider bit 8 down to divider bit 0.
- R5: A rising edge of ser_load_i while pload_i is high copies the whole frame into test_mode_o, out_sel_o and fb_div_o in one step.
- R6: A rising edge of ser_load_i while pload_i is low leaves every configuration output unchanged.
- R7: In parallel mode (pload_i low) status_o is 0.
- R8: In serial mode with test_mode_o = 0, status_o shows the most significant bit of the shift register, which allows readback of the shifted data.
- R9: In serial mode, test_mode_o = 1 drives status_o to 1, test_mode_o = 2 drives status_o to 0, and test_mode_o = 3 drives status_o to the XOR of all nine bits of fb_div_o.
- R10: div_clear_o follows mr_i after two-stage synchronization. A master reset changes none of fb_div_o, out_sel_o or test_mode_o.
- R11: If more than 13 bits are shifted before a transfer, only the last 13 bits are transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| mr_i | input | 1 | Master reset for the divider counters, asynchronous |
| pload_i | input | 1 | Parallel load strobe; its level also selects the mode (high = serial) |
| par_div_i | input | 9 | Parallel feedback divider value |
| par_sel_i | input | 2 | Parallel output divider select |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, sampled on the ser_clk_i rising edge |
| ser_load_i | input | 1 | Serial transfer strobe |
| fb_div_o | output | 9 | Loaded feedback divider value |
| out_sel_o | output | 2 | Loaded output divider select |
| test_mode_o | output | 2 | Loaded test-mode field |
| status_o | output | 1 | Test/status output |
| div_clear_o | output | 1 | Synchronized master reset for the divider counters |

## Verification
Some properties are checked on every cycle. The shift register always advances by exactly one bit on a serial-clock event. The configuration stays still unless a valid load event occurs. A serial transfer in parallel mode and a master reset leave the configuration unchanged. The status pin is low in parallel mode. Other behaviours can only be shown by the bench's scenarios. These include the end-to-end bit order of a frame, the meaning of each test-mode value at the status pin, readback of the shift register, over-length frames, and the latency from a pin edge to a visible register value.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int DIV_W   = 9;
  localparam int SEL_W   = 2;
  localparam int TM_W    = 2;
  localparam int FRAME_W = TM_W + SEL_W + DIV_W;
  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(200);

  // Field order matches the serial frame, test mode in the top bits.
  typedef struct packed {
    logic [TM_W-1:0]  tmode;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } cfg_t;

  typedef enum logic [TM_W-1:0] {
    TM_READBACK = 2'b00,
    TM_FORCE_HI = 2'b01,
    TM_FORCE_LO = 2'b10,
    TM_PARITY   = 2'b11
  } tmode_e;

  function automatic cfg_t frame_to_cfg(input logic [FRAME_W-1:0] frame);
    return cfg_t'(frame);
  endfunction

  function automatic logic status_value(input logic serial_mode,
                                        input logic [TM_W-1:0] tmode,
                                        input logic sh_top,
                                        input logic [DIV_W-1:0] div);
    if (!serial_mode) return 1'b0;
    case (tmode_e'(tmode))
      TM_READBACK: return sh_top;
      TM_FORCE_HI: return 1'b1;
      TM_FORCE_LO: return 1'b0;
      default:     return ^div;
    endcase
  endfunction
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], async_i};
  end

  assign level_o = pipe[STAGES-1];
  assign rise_o  = pipe[STAGES-1] & ~pipe[STAGES];

  // An edge event lasts exactly one system-clock cycle (supports R2, R5).
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_i,
  output logic [WIDTH-1:0] frame_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame_o <= '0;
    else if (shift_en) frame_o <= {frame_o[WIDTH-2:0], bit_i};
  end

  // New bit enters at the bottom, older bits move one place up (R4, R11).
  p_shift_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (frame_o[0] == $past(bit_i)) &&
                 (frame_o[WIDTH-1:1] == $past(frame_o[WIDTH-2:0])));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(frame_o));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mr_i,
  input  logic             pload_i,
  input  logic [DIV_W-1:0] par_div_i,
  input  logic [SEL_W-1:0] par_sel_i,
  input  logic             ser_clk_i,
  input  logic             ser_data_i,
  input  logic             ser_load_i,
  output logic [DIV_W-1:0] fb_div_o,
  output logic [SEL_W-1:0] out_sel_o,
  output logic [TM_W-1:0]  test_mode_o,
  output logic             status_o,
  output logic             div_clear_o
);
  localparam int N_CTL   = 4;
  localparam int IX_PL   = 0;
  localparam int IX_SCLK = 1;
  localparam int IX_SLD  = 2;
  localparam int IX_MR   = 3;

  logic [N_CTL-1:0] ctl_async, ctl_level, ctl_rise;
  assign ctl_async = {mr_i, ser_load_i, ser_clk_i, pload_i};

  for (genvar g = 0; g < N_CTL; g++) begin : g_sync
    cfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ctl_async[g]),
      .level_o (ctl_level[g]),
      .rise_o  (ctl_rise[g])
    );
  end

  // Named internal events for the assertions.
  logic serial_mode, par_load_ev, shift_ev, xfer_ev, sload_blocked_ev;
  assign serial_mode      = ctl_level[IX_PL];
  assign par_load_ev      = ctl_rise[IX_PL];
  assign shift_ev         = ctl_rise[IX_SCLK];
  assign xfer_ev          = ctl_rise[IX_SLD] & serial_mode & ~par_load_ev;
  assign sload_blocked_ev = ctl_rise[IX_SLD] & ~serial_mode;

  logic [FRAME_W-1:0] shreg;

  cfg_shift_reg #(.WIDTH(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_ev),
    .bit_i    (ser_data_i),
    .frame_o  (shreg)
  );

  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{tmode: '0, sel: '0, div: DIV_RESET};
    end else if (par_load_ev) begin
      cfg_q <= '{tmode: TM_READBACK, sel: par_sel_i, div: par_div_i};
    end else if (xfer_ev) begin
      cfg_q <= frame_to_cfg(shreg);
    end
  end

  assign fb_div_o    = cfg_q.div;
  assign out_sel_o   = cfg_q.sel;
  assign test_mode_o = cfg_q.tmode;
  assign status_o    = status_value(serial_mode, cfg_q.tmode, shreg[FRAME_W-1], cfg_q.div);
  assign div_clear_o = ctl_level[IX_MR];

  // R2: a parallel load takes the pins and clears the test mode.
  p_par_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    par_load_ev |=> (fb_div_o == $past(par_div_i)) && (out_sel_o == $past(par_sel_i))
                    && (test_mode_o == '0));

  // R3: with no load event the configuration holds.
  p_hold_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !par_load_ev && !xfer_ev |=> $stable(cfg_q));

  // R6: a transfer strobe in parallel mode changes nothing.
  p_sload_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sload_blocked_ev && !par_load_ev |=> $stable(cfg_q));

  // R7: status low in parallel mode.
  p_status_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_mode |-> !status_o);

  // R10: master reset never disturbs the configuration.
  p_mr_keeps_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    div_clear_o && !par_load_ev && !xfer_ev |=> $stable(cfg_q));
endmodule

// File: tb/sim_synth_cfg_loader.sv
module sim_synth_cfg_loader;
  localparam time CLK_HALF = 10ns;   // 50 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mr_i = 1'b0, pload_i = 1'b0;
  logic [8:0] par_div_i = '0;
  logic [1:0] par_sel_i = '0;
  logic       ser_clk_i = 1'b0, ser_data_i = 1'b0, ser_load_i = 1'b0;
  logic [8:0] fb_div_o;
  logic [1:0] out_sel_o, test_mode_o;
  logic       status_o, div_clear_o;

  always #CLK_HALF clk = ~clk;

  synth_cfg_loader u0 (
    .clk(clk), .rst_n(rst_n), .mr_i(mr_i), .pload_i(pload_i),
    .par_div_i(par_div_i), .par_sel_i(par_sel_i),
    .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i), .ser_load_i(ser_load_i),
    .fb_div_o(fb_div_o), .out_sel_o(out_sel_o), .test_mode_o(test_mode_o),
    .status_o(status_o), .div_clear_o(div_clear_o)
  );

  typedef struct {
    string      tag;
    logic [8:0] div;
    logic [1:0] sel;
    logic [1:0] tm;
    logic       st;
    logic       clr;
  } exp_t;

  exp_t sb_q[$];
  int   errors = 0, checks = 0;
  bit   done = 0;

  // Bench model of the block state.
  logic [8:0]  m_div = 9'd200;
  logic [1:0]  m_sel = 2'd0, m_tm = 2'd0;
  logic [12:0] m_sh = '0;
  logic        m_clr = 1'b0;

  function automatic logic exp_status();
    int ones = 0;
    if (!pload_i) return 1'b0;
    if (m_tm == 2'd0) return m_sh[12];
    if (m_tm == 2'd1) return 1'b1;
    if (m_tm == 2'd2) return 1'b0;
    for (int i = 0; i < 9; i++) if (m_div[i]) ones++;
    return (ones % 2) == 1;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    wait_clk(5);
    e.tag = tag; e.div = m_div; e.sel = m_sel; e.tm = m_tm;
    e.st = exp_status(); e.clr = m_clr;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
  endtask

  task automatic set_pload(input logic lvl);
    wait_clk(1);
    if (lvl && !pload_i) begin
      m_div = par_div_i; m_sel = par_sel_i; m_tm = 2'd0;
    end
    pload_i = lvl;
    wait_clk(4);
  endtask

  task automatic par_load(input logic [8:0] d, input logic [1:0] s);
    set_pload(1'b0);
    par_div_i = d; par_sel_i = s;
    wait_clk(2);
    set_pload(1'b1);
  endtask

  task automatic shift_bit(input logic b);
    ser_data_i = b;
    wait_clk(2);
    ser_clk_i = 1'b1;
    m_sh = {m_sh[11:0], b};
    wait_clk(4);
    ser_clk_i = 1'b0;
    wait_clk(2);
  endtask

  task automatic send_frame(input logic [1:0] t, input logic [1:0] s, input logic [8:0] d);
    logic [12:0] f;
    f = {t, s, d};
    for (int i = 12; i >= 0; i--) shift_bit(f[i]);
  endtask

  task automatic sload_pulse();
    ser_load_i = 1'b1;
    if (pload_i) begin
      m_tm = m_sh[12:11]; m_sel = m_sh[10:9]; m_div = m_sh[8:0];
    end
    wait_clk(4);
    ser_load_i = 1'b0;
    wait_clk(4);
  endtask

  // Monitor: pops expected items and compares them to the outputs.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (fb_div_o !== e.div || out_sel_o !== e.sel || test_mode_o !== e.tm ||
            status_o !== e.st || div_clear_o !== e.clr) begin
          errors++;
          $display("FAIL %s: got div=%0d sel=%0d tm=%0d st=%b clr=%b, expected div=%0d sel=%0d tm=%0d st=%b clr=%b",
                   e.tag, fb_div_o, out_sel_o, test_mode_o, status_o, div_clear_o,
                   e.div, e.sel, e.tm, e.st, e.clr);
        end
      end
    end
  end

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    expect_now("R1 reset defaults");

    par_div_i = 9'h0AB; par_sel_i = 2'd3;
    expect_now("R3 R7 pins ignored in parallel mode");

    par_load(9'h1A5, 2'd2);
    expect_now("R2 parallel capture, R8 readback of empty shift register");

    par_div_i = 9'h011; par_sel_i = 2'd1;
    expect_now("R3 pins ignored while strobe held high");

    send_frame(2'd2, 2'd1, 9'h0F3);
    expect_now("R8 readback shows first frame bit before transfer");

    sload_pulse();
    expect_now("R5 R4 serial transfer with tmode 2, R9 forced low");

    send_frame(2'd1, 2'd3, 9'h155);
    sload_pulse();
    expect_now("R9 tmode 1 forces status high");

    send_frame(2'd3, 2'd0, 9'h0B6);
    sload_pulse();
    expect_now("R9 tmode 3 gives divider parity (odd)");

    send_frame(2'd3, 2'd1, 9'h0B7);
    sload_pulse();
    expect_now("R9 tmode 3 gives divider parity (even)");

    set_pload(1'b0);
    expect_now("R7 status low in parallel mode");

    send_frame(2'd0, 2'd2, 9'h033);
    sload_pulse();
    expect_now("R6 serial transfer ignored in parallel mode");

    par_div_i = 9'h0C8; par_sel_i = 2'd0;
    set_pload(1'b1);
    shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b0);
    send_frame(2'd0, 2'd3, 9'h12C);
    sload_pulse();
    expect_now("R11 only last 13 bits transferred, R4 order");

    mr_i = 1'b1; m_clr = 1'b1;
    expect_now("R10 master reset asserted, configuration kept");

    send_frame(2'd1, 2'd2, 9'h003);
    sload_pulse();
    expect_now("R10 loads still work during master reset");

    mr_i = 1'b0; m_clr = 1'b0;
    expect_now("R10 master reset released, configuration kept");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule